// File: doc/BRIEF.md
# Preemptive Level-Priority Interrupt Arbiter

This block sits between a bank of interrupt sources and a processor core. Every source presents a pending bit, an enable bit, a level, a priority and a one-bit attribute that says whether the handler is entered through a vector table or through a shared entry. The inputs are captured in a register stage. From the captured copy, the block picks one winner among the sources that are both pending and enabled. The highest level wins. Priority breaks a tie in level, and the higher source number breaks a tie in both.

The block keeps the level of the handler now running. A value of 0 means normal execution. A take request goes to the core only when the captured global enable is set and the winner's level is strictly above the running level. A winner at the same level or below remains visible on the outputs. It is not requested, so it can be taken once the running handler returns, which allows handlers to be chained.

The core acknowledges a take with a one-cycle strobe. The block then saves the running level on an internal stack and adopts the winner's level. A handler-return strobe restores the saved level. The stack depth follows from the level width: preemption needs a strictly rising level, so nesting cannot exceed the number of non-zero levels.

Top module: `irqPreemptArb`

## Requirements
- R1: A source whose captured enable bit is 0, or whose captured pending bit is 0, never becomes the winner. When no source is both pending and enabled, winValid is 0 and takeReq is 0.
- R2: Among eligible sources, the one with the numerically largest level wins, whatever the priorities and source numbers are.
- R3: Among eligible sources of equal highest level, the one with the numerically largest priority wins.
- R4: When both level and priority are equal, the source with the larger index wins.
- R5: takeReq is 0 in every cycle whose captured global enable is 0.
- R6: takeReq is 1 only when the winner's level is strictly greater than curLevel. A winner at a level equal to or below curLevel stays on winId and winLevel with takeReq at 0.
- R7: All source inputs and globalIe take effect on the outputs exactly one clock edge after they are presented. winId, winLevel and winVec (1 = vectored) describe the winner in the same cycle as takeReq.
- R8: takeAck in a cycle with takeReq at 1 sets curLevel to winLevel at the next edge and saves the previous curLevel. takeAck while takeReq is 0 leaves curLevel unchanged.
- R9: handlerRet restores the curLevel saved by the most recent unreturned take, so nested takes unwind in reverse order. handlerRet with nothing saved leaves curLevel unchanged.
- R10: takeAck with takeReq at 1 and handlerRet in the same cycle set curLevel to winLevel without changing the nesting depth. The following handlerRet restores the level saved before the returning handler.
- R11: After reset, curLevel is 0 and takeReq and winValid are 0.
- R12: An eligible source of level 0 can win, but it never raises takeReq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcPend | input | NUM_SRC | Pending bit per source |
| srcEn | input | NUM_SRC | Enable bit per source |
| srcLevel | input | NUM_SRC x LVL_W | Level per source |
| srcPrio | input | NUM_SRC x PRIO_W | Priority per source |
| srcVec | input | NUM_SRC | Vectored attribute per source (1 = vectored) |
| globalIe | input | 1 | Global interrupt enable |
| takeAck | input | 1 | Core accepts the offered interrupt |
| handlerRet | input | 1 | Running handler returns |
| takeReq | output | 1 | Request to take the winner |
| winValid | output | 1 | At least one source is eligible |
| winId | output | ID_W | Index of the winner |
| winLevel | output | LVL_W | Level of the winner |
| winVec | output | 1 | Vectored attribute of the winner |
| curLevel | output | LVL_W | Level of the running handler, 0 when none |

## Verification
A wrong running level shows at the ports as soon as a source is pending at the boundary: takeReq is either raised for a source at the same level or held back for a source one level higher, in the cycle after that source is presented. A fault in the arbitration order shows on winId one edge after the competing sources appear. A corrupted save stack stays hidden until the matching handlerRet, when curLevel returns to the wrong value. The bench therefore unwinds nested takes completely and then probes the threshold again.

// File: rtl/irqArbPkg.sv
package irqArbPkg;

  // Strobes from the control to the level-tracking datapath
  typedef struct packed {
    logic push;   // new handler entered: save level, adopt winner level
    logic pop;    // handler returned: restore saved level
    logic swap;   // return and entry in one cycle: adopt winner level, keep depth
  } lvlStrobe_t;

endpackage

// File: rtl/irqArbDatapath.sv
module irqArbDatapath #(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3,
  parameter int PRIO_W  = 2,
  localparam int ID_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_SRC-1:0]               srcPend,
  input  logic [NUM_SRC-1:0]               srcEn,
  input  logic [NUM_SRC-1:0][LVL_W-1:0]    srcLevel,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0]   srcPrio,
  input  logic [NUM_SRC-1:0]               srcVec,
  input  logic                             globalIe,
  input  irqArbPkg::lvlStrobe_t            strobe,
  output logic                             ieQ,
  output logic                             winValid,
  output logic [ID_W-1:0]                  winId,
  output logic [LVL_W-1:0]                 winLevel,
  output logic                             winVec,
  output logic [LVL_W-1:0]                 curLevel
);

  localparam int DEPTH   = (1 << LVL_W) - 1;
  localparam int SP_W    = $clog2(DEPTH + 1);
  localparam int ENTRIES = 1 << SP_W;

  // ---------------- input capture stage ----------------
  logic [NUM_SRC-1:0]             pendQ, enQ, vecQ;
  logic [NUM_SRC-1:0][LVL_W-1:0]  lvlQ;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prioQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      enQ   <= '0;
      vecQ  <= '0;
      lvlQ  <= '0;
      prioQ <= '0;
      ieQ   <= 1'b0;
    end else begin
      pendQ <= srcPend;
      enQ   <= srcEn;
      vecQ  <= srcVec;
      lvlQ  <= srcLevel;
      prioQ <= srcPrio;
      ieQ   <= globalIe;
    end
  end

  // ---------------- arbitration chain ----------------
  logic              stValid [NUM_SRC+1];
  logic [ID_W-1:0]   stId    [NUM_SRC+1];
  logic [LVL_W-1:0]  stLvl   [NUM_SRC+1];
  logic [PRIO_W-1:0] stPrio  [NUM_SRC+1];
  logic              stVec   [NUM_SRC+1];

  assign stValid[0] = 1'b0;
  assign stId[0]    = '0;
  assign stLvl[0]   = '0;
  assign stPrio[0]  = '0;
  assign stVec[0]   = 1'b0;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_stage
    logic eligible;
    logic beats;
    assign eligible = pendQ[i] & enQ[i];
    // later index replaces on a full tie, so the higher ID wins
    assign beats = eligible &
                   (~stValid[i] | ({lvlQ[i], prioQ[i]} >= {stLvl[i], stPrio[i]}));
    assign stValid[i+1] = stValid[i] | eligible;
    assign stId[i+1]    = beats ? ID_W'(i)  : stId[i];
    assign stLvl[i+1]   = beats ? lvlQ[i]   : stLvl[i];
    assign stPrio[i+1]  = beats ? prioQ[i]  : stPrio[i];
    assign stVec[i+1]   = beats ? vecQ[i]   : stVec[i];
  end

  assign winValid = stValid[NUM_SRC];
  assign winId    = stId[NUM_SRC];
  assign winLevel = stLvl[NUM_SRC];
  assign winVec   = stVec[NUM_SRC];

  // ---------------- running-level stack ----------------
  logic [LVL_W-1:0] savedLvl [ENTRIES];
  logic [SP_W-1:0]  spQ;
  logic [LVL_W-1:0] curQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spQ  <= '0;
      curQ <= '0;
    end else if (strobe.push) begin
      if (spQ != SP_W'(DEPTH)) begin
        spQ  <= spQ + 1'b1;
        curQ <= winLevel;
      end
    end else if (strobe.pop) begin
      if (spQ != '0) begin
        spQ  <= spQ - 1'b1;
        curQ <= savedLvl[spQ - 1'b1];
      end
    end else if (strobe.swap) begin
      curQ <= winLevel;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.push && spQ != SP_W'(DEPTH)) begin
      savedLvl[spQ] <= curQ;
    end
  end

  assign curLevel = curQ;

endmodule

// File: rtl/irqArbCtrl.sv
module irqArbCtrl #(
  parameter int LVL_W = 3
) (
  input  logic                   ieQ,
  input  logic                   winValid,
  input  logic [LVL_W-1:0]       winLevel,
  input  logic [LVL_W-1:0]       curLevel,
  input  logic                   takeAck,
  input  logic                   handlerRet,
  output logic                   takeReq,
  output irqArbPkg::lvlStrobe_t  strobe
);

  logic accepted;

  always_comb begin
    takeReq  = ieQ & winValid & (winLevel > curLevel);
    accepted = takeAck & takeReq;
    strobe.push = accepted & ~handlerRet;
    strobe.pop  = handlerRet & ~accepted;
    strobe.swap = accepted & handlerRet;
  end

endmodule

// File: rtl/irqPreemptArb.sv
module irqPreemptArb #(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3,
  parameter int PRIO_W  = 2,
  localparam int ID_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_SRC-1:0]             srcPend,
  input  logic [NUM_SRC-1:0]             srcEn,
  input  logic [NUM_SRC-1:0][LVL_W-1:0]  srcLevel,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] srcPrio,
  input  logic [NUM_SRC-1:0]             srcVec,
  input  logic                           globalIe,
  input  logic                           takeAck,
  input  logic                           handlerRet,
  output logic                           takeReq,
  output logic                           winValid,
  output logic [ID_W-1:0]                winId,
  output logic [LVL_W-1:0]               winLevel,
  output logic                           winVec,
  output logic [LVL_W-1:0]               curLevel
);

  irqArbPkg::lvlStrobe_t strobe;
  logic ieQ;

  irqArbDatapath #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .PRIO_W(PRIO_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .srcPend(srcPend), .srcEn(srcEn), .srcLevel(srcLevel),
    .srcPrio(srcPrio), .srcVec(srcVec), .globalIe(globalIe),
    .strobe(strobe), .ieQ(ieQ),
    .winValid(winValid), .winId(winId), .winLevel(winLevel),
    .winVec(winVec), .curLevel(curLevel)
  );

  irqArbCtrl #(.LVL_W(LVL_W)) u_ctrl (
    .ieQ(ieQ), .winValid(winValid), .winLevel(winLevel), .curLevel(curLevel),
    .takeAck(takeAck), .handlerRet(handlerRet),
    .takeReq(takeReq), .strobe(strobe)
  );

endmodule

// File: rtl/irqPreemptArbChk.sv
module irqPreemptArbChk #(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3,
  parameter int ID_W    = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_SRC-1:0]  srcPend,
  input logic [NUM_SRC-1:0]  srcEn,
  input logic                globalIe,
  input logic                takeAck,
  input logic                handlerRet,
  input logic                takeReq,
  input logic                winValid,
  input logic [ID_W-1:0]     winId,
  input logic [LVL_W-1:0]    winLevel,
  input logic [LVL_W-1:0]    curLevel
);

  logic [NUM_SRC-1:0] eligPrev;
  logic               iePrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eligPrev <= '0;
      iePrev   <= 1'b0;
    end else begin
      eligPrev <= srcPend & srcEn;
      iePrev   <= globalIe;
    end
  end

  // R1: the winner was pending and enabled one edge earlier
  a_r1_winner_eligible: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> eligPrev[winId]);

  // R5: no request unless the global enable was set one edge earlier
  a_r5_no_take_without_ie: assert property (@(posedge clk) disable iff (!rstN)
    takeReq |-> iePrev);

  // R12: a level-0 winner is never requested
  a_r12_level0_never_taken: assert property (@(posedge clk) disable iff (!rstN)
    takeReq |-> (winLevel != '0));

  // R8: an accepted take moves the running level to the winner level
  a_r8_take_adopts_level: assert property (@(posedge clk) disable iff (!rstN)
    (takeAck && takeReq) |=> (curLevel == $past(winLevel)));

  // R8: an acknowledge without a request changes nothing
  a_r8_stray_ack_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (takeAck && !takeReq && !handlerRet) |=> $stable(curLevel));

  // R6: the running level never exceeds a requested winner
  a_r6_strictly_above: assert property (@(posedge clk) disable iff (!rstN)
    (takeReq && takeAck) |=> (curLevel > $past(curLevel)));

endmodule

bind irqPreemptArb irqPreemptArbChk #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rstN(rstN), .srcPend(srcPend), .srcEn(srcEn),
  .globalIe(globalIe), .takeAck(takeAck), .handlerRet(handlerRet),
  .takeReq(takeReq), .winValid(winValid), .winId(winId),
  .winLevel(winLevel), .curLevel(curLevel)
);

// File: tb/test_irqPreemptArb.sv
module test_irqPreemptArb;

  localparam int NUM_SRC = 8;
  localparam int LVL_W   = 3;
  localparam int PRIO_W  = 2;
  localparam int ID_W    = 3;

  logic                           clk = 1'b0;
  logic                           rstN = 1'b0;
  logic [NUM_SRC-1:0]             srcPend = '0;
  logic [NUM_SRC-1:0]             srcEn = '0;
  logic [NUM_SRC-1:0][LVL_W-1:0]  srcLevel = '0;
  logic [NUM_SRC-1:0][PRIO_W-1:0] srcPrio = '0;
  logic [NUM_SRC-1:0]             srcVec = '0;
  logic                           globalIe = 1'b0;
  logic                           takeAck = 1'b0;
  logic                           handlerRet = 1'b0;
  logic                           takeReq, winValid, winVec;
  logic [ID_W-1:0]                winId;
  logic [LVL_W-1:0]               winLevel, curLevel;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  irqPreemptArb #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .PRIO_W(PRIO_W)) i_irqPreemptArb (
    .clk(clk), .rstN(rstN), .srcPend(srcPend), .srcEn(srcEn),
    .srcLevel(srcLevel), .srcPrio(srcPrio), .srcVec(srcVec),
    .globalIe(globalIe), .takeAck(takeAck), .handlerRet(handlerRet),
    .takeReq(takeReq), .winValid(winValid), .winId(winId),
    .winLevel(winLevel), .winVec(winVec), .curLevel(curLevel)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic setSrc(input int i, input bit p, input bit e,
                        input int lvl, input int pr, input bit v);
    srcPend[i]  = p;
    srcEn[i]    = e;
    srcLevel[i] = LVL_W'(lvl);
    srcPrio[i]  = PRIO_W'(pr);
    srcVec[i]   = v;
  endtask

  task automatic clearSrc();
    srcPend = '0; srcEn = '0; srcLevel = '0; srcPrio = '0; srcVec = '0;
  endtask

  // inputs are driven at a negedge; one edge later they are visible
  task automatic settle();
    @(negedge clk);
  endtask

  task automatic pulse(input bit ack, input bit ret);
    takeAck = ack; handlerRet = ret;
    @(negedge clk);
    takeAck = 1'b0; handlerRet = 1'b0;
  endtask

  task automatic testReset();
    chk("R11 curLevel", curLevel, 0);
    chk("R11 takeReq", takeReq, 0);
    chk("R11 winValid", winValid, 0);
  endtask

  task automatic testDisabled();
    clearSrc(); globalIe = 1'b1;
    setSrc(5, 1, 0, 7, 3, 0);
    setSrc(2, 1, 1, 1, 0, 0);
    setSrc(6, 0, 1, 6, 3, 0);
    settle();
    chk("R1 disabled/not-pending skipped winId", winId, 2);
    chk("R1 winLevel", winLevel, 1);
    setSrc(2, 1, 0, 1, 0, 0);
    settle();
    chk("R1 none eligible winValid", winValid, 0);
    chk("R1 none eligible takeReq", takeReq, 0);
  endtask

  task automatic testLevel();
    clearSrc();
    setSrc(1, 1, 1, 6, 0, 0);
    setSrc(6, 1, 1, 3, 3, 0);
    setSrc(7, 1, 1, 5, 3, 0);
    settle();
    chk("R2 highest level winId", winId, 1);
    chk("R2 highest level winLevel", winLevel, 6);
  endtask

  task automatic testPrio();
    clearSrc();
    setSrc(1, 1, 1, 4, 1, 0);
    setSrc(3, 1, 1, 4, 2, 0);
    setSrc(6, 1, 1, 4, 0, 0);
    setSrc(7, 1, 1, 2, 3, 0);
    settle();
    chk("R3 priority tie-break winId", winId, 3);
  endtask

  task automatic testId();
    clearSrc();
    setSrc(2, 1, 1, 4, 2, 0);
    setSrc(3, 1, 1, 4, 2, 0);
    setSrc(6, 1, 1, 4, 2, 0);
    settle();
    chk("R4 higher id wins", winId, 6);
    setSrc(6, 1, 0, 4, 2, 0);
    settle();
    chk("R4 next higher id wins", winId, 3);
  endtask

  task automatic testGlobalIe();
    clearSrc();
    setSrc(4, 1, 1, 5, 0, 0);
    globalIe = 1'b0;
    settle();
    chk("R5 globalIe 0 takeReq", takeReq, 0);
    chk("R5 winner still shown", winId, 4);
    globalIe = 1'b1;
    chk("R7 globalIe not yet captured", takeReq, 0);
    settle();
    chk("R5 globalIe 1 takeReq", takeReq, 1);
  endtask

  task automatic testVec();
    clearSrc();
    setSrc(4, 1, 1, 3, 0, 1);
    setSrc(0, 1, 1, 2, 0, 0);
    settle();
    chk("R7 winVec of vectored winner", winVec, 1);
    chk("R7 takeReq with winner", takeReq, 1);
    setSrc(0, 1, 1, 6, 0, 0);
    chk("R7 old winner held before edge", winId, 4);
    settle();
    chk("R7 winId after edge", winId, 0);
    chk("R7 winVec of non-vectored winner", winVec, 0);
  endtask

  task automatic testNest();
    clearSrc();
    setSrc(1, 1, 1, 2, 0, 0);
    settle();
    chk("R6 level 2 above 0 takeReq", takeReq, 1);
    pulse(1, 0);
    chk("R8 curLevel after take", curLevel, 2);
    chk("R6 equal level not requested", takeReq, 0);
    chk("R6 equal level winner shown", winId, 1);
    setSrc(3, 1, 1, 1, 3, 0);
    settle();
    chk("R6 lower level not requested", takeReq, 0);
    setSrc(5, 1, 1, 5, 0, 0);
    settle();
    chk("R6 higher level requested", takeReq, 1);
    pulse(1, 0);
    chk("R8 nested curLevel", curLevel, 5);
    setSrc(5, 0, 1, 5, 0, 0);
    setSrc(6, 1, 1, 5, 0, 0);
    settle();
    chk("R6 equal to nested level held", takeReq, 0);
    pulse(0, 1);
    chk("R9 return restores 2", curLevel, 2);
    chk("R6 pending level 5 now requested", takeReq, 1);
    setSrc(6, 0, 1, 5, 0, 0);
    pulse(0, 1);
    chk("R9 return restores 0", curLevel, 0);
    pulse(0, 1);
    chk("R9 extra return ignored", curLevel, 0);
    chk("R9 chained source requested", takeReq, 1);
  endtask

  task automatic testStrayAck();
    clearSrc();
    setSrc(2, 1, 1, 4, 0, 0);
    globalIe = 1'b0;
    settle();
    pulse(1, 0);
    chk("R8 ack without request ignored", curLevel, 0);
    globalIe = 1'b1;
    settle();
  endtask

  task automatic testSwap();
    clearSrc();
    setSrc(2, 1, 1, 3, 0, 0);
    settle();
    pulse(1, 0);
    chk("R10 setup curLevel", curLevel, 3);
    setSrc(2, 0, 1, 3, 0, 0);
    setSrc(7, 1, 1, 6, 0, 1);
    settle();
    chk("R10 request before swap", takeReq, 1);
    pulse(1, 1);
    chk("R10 swap adopts winner level", curLevel, 6);
    setSrc(7, 0, 1, 6, 0, 1);
    pulse(0, 1);
    chk("R10 depth kept, return to 0", curLevel, 0);
  endtask

  task automatic testLevelZero();
    clearSrc();
    setSrc(3, 1, 1, 0, 3, 0);
    settle();
    chk("R12 level 0 winValid", winValid, 1);
    chk("R12 level 0 winId", winId, 3);
    chk("R12 level 0 no takeReq", takeReq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    settle();
    testReset();
    testDisabled();
    testLevel();
    testPrio();
    testId();
    testGlobalIe();
    testVec();
    testNest();
    testStrayAck();
    testSwap();
    testLevelZero();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule